// File: doc/BRIEF.md
# Stage Stall and Squash Controller

This block is the flow-control state machine of one out-of-order pipeline stage placed between rename and commit. Each cycle it decides whether the stage accepts the instruction group arriving from upstream or parks it, and it holds a stall request upstream while it cannot take new work. A small FIFO of group tags, the skid buffer, catches groups that arrive while the stage is held. That buffer is drained one tag per cycle once the hold is released.

Commit can hold the stage with a stall flag, or flush it with either of two squash flags (a commit squash and a reorder-buffer squash). The controller moves through five states: idle, running, blocked, unblocking and squashing. While squashing it pulses a step request to the issue queue every cycle. It also forwards the issue queue's free-entry count upstream with one register of delay, in every state.

Top module: `stage_flow_ctrl`

## Requirements
- R1: During and right after reset the state output is Idle. The state codes are Idle=0, Running=1, Blocked=2, Unblocking=3 and Squashing=4. After reset the stall output is low, the skid buffer is empty, the overflow flag is low and the forwarded free count is 0.
- R2: In Idle, Running or Unblocking, an asserted commit stall gives Blocked in the next cycle, even if a squash flag is also high. In that cycle a valid upstream group is pushed into the skid buffer.
- R3: While the state is Blocked, the upstream stall output is high every cycle and every valid upstream group is pushed into the skid buffer.
- R4: From Blocked, either squash flag gives Squashing and takes priority. Otherwise, commit stall low together with queue-full low gives Unblocking. In all other cases the state stays Blocked.
- R5: In Unblocking with no stall, squash or full-queue event, one tag is popped per cycle and presented on the head output. A valid upstream group is pushed behind the others. The stall output is high while entries remain after that cycle, and the state becomes Running once none remain.
- R6: In Squashing, the squash-step output is high each cycle while either squash flag is high, and the state stays Squashing. When both flags are low, the next state is Running.
- R7: In Idle, Running or Unblocking with no commit stall, either squash flag gives Squashing in the next cycle. Any incoming group is dropped. Every transition into Squashing empties the skid buffer.
- R8: In Idle, Running or Unblocking with no stall and no squash, a valid group that meets a full issue queue gives Blocked. The group is pushed and the stall output goes high in that same cycle.
- R9: Idle stays Idle when no event and no valid group occur. A valid group with no other event moves Idle to Running.
- R10: A push into a full skid buffer, with no pop in the same cycle, is dropped and sets a sticky overflow flag that only reset clears.
- R11: The forwarded free count equals the queue free-count input of the previous cycle, in every state.
- R12: Tags leave the skid buffer in the order they entered it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit_stall_i | input | 1 | Hold request from commit |
| commit_squash_i | input | 1 | Squash request from commit |
| rob_squash_i | input | 1 | Reorder buffer squash in progress |
| up_valid_i | input | 1 | Upstream group present this cycle |
| up_tag_i | input | TAG_W | Tag of the upstream group |
| queue_full_i | input | 1 | Issue queue has no free entry |
| queue_free_i | input | FREE_W | Issue queue free-entry count |
| up_stall_o | output | 1 | Stall request to upstream |
| state_o | output | 3 | Current state code |
| skid_push_o | output | 1 | Skid buffer push this cycle |
| skid_pop_o | output | 1 | Skid buffer pop this cycle |
| skid_empty_o | output | 1 | Skid buffer holds no tag |
| skid_head_o | output | TAG_W | Tag at the skid buffer head |
| squash_step_o | output | 1 | Per-cycle squash step to the issue queue |
| overflow_o | output | 1 | Sticky skid overflow flag |
| free_cnt_o | output | FREE_W | Free count forwarded upstream |

## Verification
The properties assume only that every input is driven to a known 0 or 1 at each rising edge. They do not rely on upstream honouring the stall, because the controller is defined to accept, or count as overflow, a group that arrives while it is stalling. For that reason the random phase draws every flag independently and often sends valid groups into a stalled or full stage. The directed phases set up exact cases: a stall and a squash arriving together, squash arriving in Blocked, a push during the drain, and a fifth push into a four-entry buffer.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RUN    = 3'd1,
        ST_BLOCK  = 3'd2,
        ST_UNBLK  = 3'd3,
        ST_SQUASH = 3'd4
    } stage_st_e;

endpackage

// File: rtl/sfc_fsm.sv
module sfc_fsm
    import sfc_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_stall_i,
    input  logic             squash_req_i,
    input  logic             up_valid_i,
    input  logic             queue_full_i,
    input  logic [CNT_W-1:0] skid_cnt_i,
    output stage_st_e        state_o,
    output logic             push_o,
    output logic             pop_o,
    output logic             flush_o,
    output logic             stall_o,
    output logic             step_o
);

    typedef struct packed {
        stage_st_e st;
    } fsm_regs_t;

    fsm_regs_t      r_q, r_d;
    logic [CNT_W:0] remain;

    always_comb begin
        r_d     = r_q;
        push_o  = 1'b0;
        pop_o   = 1'b0;
        flush_o = 1'b0;
        stall_o = 1'b0;
        step_o  = 1'b0;
        remain  = '0;
        unique case (r_q.st)
            ST_IDLE, ST_RUN, ST_UNBLK: begin
                if (commit_stall_i) begin
                    r_d.st = ST_BLOCK;
                    push_o = up_valid_i;
                end else if (squash_req_i) begin
                    r_d.st  = ST_SQUASH;
                    flush_o = 1'b1;
                end else if (queue_full_i && up_valid_i) begin
                    r_d.st  = ST_BLOCK;
                    push_o  = 1'b1;
                    stall_o = 1'b1;
                end else if (r_q.st == ST_UNBLK) begin
                    pop_o   = (skid_cnt_i != '0);
                    push_o  = up_valid_i;
                    remain  = {1'b0, skid_cnt_i} - {{CNT_W{1'b0}}, pop_o}
                            + {{CNT_W{1'b0}}, push_o};
                    stall_o = (remain != '0);
                    r_d.st  = stall_o ? ST_UNBLK : ST_RUN;
                end else if (up_valid_i) begin
                    r_d.st = ST_RUN;
                end
            end
            ST_BLOCK: begin
                stall_o = 1'b1;
                if (squash_req_i) begin
                    r_d.st  = ST_SQUASH;
                    flush_o = 1'b1;
                end else begin
                    push_o = up_valid_i;
                    if (!commit_stall_i && !queue_full_i) begin
                        r_d.st = ST_UNBLK;
                    end
                end
            end
            ST_SQUASH: begin
                if (squash_req_i) begin
                    step_o = 1'b1;
                end else begin
                    r_d.st = ST_RUN;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.st;

endmodule

// File: rtl/sfc_skid.sv
module sfc_skid #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             flush_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic [TAG_W-1:0] head_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             empty_o,
    output logic             ovf_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } skid_regs_t;

    skid_regs_t       s_q, s_d;
    logic             pop_ok;
    logic             accept;
    logic [TAG_W-1:0] slot [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d    = s_q;
        pop_ok = 1'b0;
        accept = 1'b0;
        if (flush_i) begin
            s_d.rd  = '0;
            s_d.wr  = '0;
            s_d.cnt = '0;
        end else begin
            pop_ok = pop_i && (s_q.cnt != '0);
            accept = push_i && ((s_q.cnt != FULL_CNT) || pop_ok);
            if (pop_ok) begin
                s_d.rd = ptr_inc(s_q.rd);
            end
            if (accept) begin
                s_d.wr = ptr_inc(s_q.wr);
            end
            if (push_i && !accept) begin
                s_d.ovf = 1'b1;
            end
            s_d.cnt = s_q.cnt + {{(CNT_W-1){1'b0}}, accept}
                              - {{(CNT_W-1){1'b0}}, pop_ok};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic [TAG_W-1:0] ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (accept && (s_q.wr == PTR_W'(i))) begin
                ent_q <= tag_i;
            end
        end
        assign slot[i] = ent_q;
    end

    assign head_o  = slot[s_q.rd];
    assign cnt_o   = s_q.cnt;
    assign empty_o = (s_q.cnt == '0);
    assign ovf_o   = s_q.ovf;

endmodule

// File: rtl/stage_flow_ctrl.sv
module stage_flow_ctrl
    import sfc_pkg::*;
#(
    parameter int SKID_DEPTH = 4,
    parameter int TAG_W      = 8,
    parameter int FREE_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_stall_i,
    input  logic              commit_squash_i,
    input  logic              rob_squash_i,
    input  logic              up_valid_i,
    input  logic [TAG_W-1:0]  up_tag_i,
    input  logic              queue_full_i,
    input  logic [FREE_W-1:0] queue_free_i,
    output logic              up_stall_o,
    output logic [2:0]        state_o,
    output logic              skid_push_o,
    output logic              skid_pop_o,
    output logic              skid_empty_o,
    output logic [TAG_W-1:0]  skid_head_o,
    output logic              squash_step_o,
    output logic              overflow_o,
    output logic [FREE_W-1:0] free_cnt_o
);

    localparam int CNT_W = $clog2(SKID_DEPTH + 1);

    typedef struct packed {
        logic [FREE_W-1:0] free;
    } top_regs_t;

    top_regs_t        t_q, t_d;
    stage_st_e        st;
    logic             push, pop, flush;
    logic [CNT_W-1:0] skid_cnt;

    sfc_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .commit_stall_i (commit_stall_i),
        .squash_req_i   (commit_squash_i | rob_squash_i),
        .up_valid_i     (up_valid_i),
        .queue_full_i   (queue_full_i),
        .skid_cnt_i     (skid_cnt),
        .state_o        (st),
        .push_o         (push),
        .pop_o          (pop),
        .flush_o        (flush),
        .stall_o        (up_stall_o),
        .step_o         (squash_step_o)
    );

    sfc_skid #(
        .DEPTH (SKID_DEPTH),
        .TAG_W (TAG_W),
        .CNT_W (CNT_W)
    ) u_skid (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (pop),
        .flush_i (flush),
        .tag_i   (up_tag_i),
        .head_o  (skid_head_o),
        .cnt_o   (skid_cnt),
        .empty_o (skid_empty_o),
        .ovf_o   (overflow_o)
    );

    always_comb begin
        t_d      = t_q;
        t_d.free = queue_free_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign state_o     = st;
    assign skid_push_o = push;
    assign skid_pop_o  = pop;
    assign free_cnt_o  = t_q.free;

endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
    parameter int TAG_W  = 8,
    parameter int FREE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              commit_stall_i,
    input logic              commit_squash_i,
    input logic              rob_squash_i,
    input logic              up_valid_i,
    input logic              queue_full_i,
    input logic [FREE_W-1:0] queue_free_i,
    input logic              up_stall_o,
    input logic [2:0]        state_o,
    input logic              skid_pop_o,
    input logic              skid_empty_o,
    input logic              squash_step_o,
    input logic              overflow_o,
    input logic [FREE_W-1:0] free_cnt_o
);

    logic active;
    logic sq_any;
    assign active = (state_o == 3'd0) || (state_o == 3'd1) || (state_o == 3'd3);
    assign sq_any = commit_squash_i || rob_squash_i;

    AST_STALL_TO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        active && commit_stall_i |=> state_o == 3'd2); // R2

    AST_BLOCK_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd2 |-> up_stall_o); // R3

    AST_BLOCK_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd2 && sq_any |=> state_o == 3'd4 && skid_empty_o); // R4

    AST_UNBLK_POPS: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd3 && !commit_stall_i && !sq_any && !(queue_full_i && up_valid_i)
        && !skid_empty_o |-> skid_pop_o); // R5

    AST_POP_ONLY_UNBLK: assert property (@(posedge clk) disable iff (!rst_n)
        skid_pop_o |-> state_o == 3'd3); // R5

    AST_SQUASH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd4 && sq_any |-> squash_step_o); // R6

    AST_SQUASH_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 3'd4 && !sq_any |=> state_o == 3'd1); // R6

    AST_ACTIVE_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
        active && !commit_stall_i && sq_any |=> state_o == 3'd4 && skid_empty_o); // R7

    AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o); // R10

    AST_FREE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> free_cnt_o == $past(queue_free_i)); // R11

endmodule

bind stage_flow_ctrl sfc_checker #(
    .TAG_W  (TAG_W),
    .FREE_W (FREE_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .commit_stall_i  (commit_stall_i),
    .commit_squash_i (commit_squash_i),
    .rob_squash_i    (rob_squash_i),
    .up_valid_i      (up_valid_i),
    .queue_full_i    (queue_full_i),
    .queue_free_i    (queue_free_i),
    .up_stall_o      (up_stall_o),
    .state_o         (state_o),
    .skid_pop_o      (skid_pop_o),
    .skid_empty_o    (skid_empty_o),
    .squash_step_o   (squash_step_o),
    .overflow_o      (overflow_o),
    .free_cnt_o      (free_cnt_o)
);

// File: tb/sim_stage_flow_ctrl.sv
module sim_stage_flow_ctrl;

    localparam int DEPTH = 4;
    localparam int TW    = 8;
    localparam int FW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          commit_stall_i = 1'b0;
    logic          commit_squash_i = 1'b0;
    logic          rob_squash_i = 1'b0;
    logic          up_valid_i = 1'b0;
    logic [TW-1:0] up_tag_i = '0;
    logic          queue_full_i = 1'b0;
    logic [FW-1:0] queue_free_i = '0;
    logic          up_stall_o;
    logic [2:0]    state_o;
    logic          skid_push_o;
    logic          skid_pop_o;
    logic          skid_empty_o;
    logic [TW-1:0] skid_head_o;
    logic          squash_step_o;
    logic          overflow_o;
    logic [FW-1:0] free_cnt_o;

    always #10ns clk = ~clk;

    stage_flow_ctrl #(
        .SKID_DEPTH (DEPTH),
        .TAG_W      (TW),
        .FREE_W     (FW)
    ) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .commit_stall_i  (commit_stall_i),
        .commit_squash_i (commit_squash_i),
        .rob_squash_i    (rob_squash_i),
        .up_valid_i      (up_valid_i),
        .up_tag_i        (up_tag_i),
        .queue_full_i    (queue_full_i),
        .queue_free_i    (queue_free_i),
        .up_stall_o      (up_stall_o),
        .state_o         (state_o),
        .skid_push_o     (skid_push_o),
        .skid_pop_o      (skid_pop_o),
        .skid_empty_o    (skid_empty_o),
        .skid_head_o     (skid_head_o),
        .squash_step_o   (squash_step_o),
        .overflow_o      (overflow_o),
        .free_cnt_o      (free_cnt_o)
    );

    int n_vec = 0;
    int n_bad = 0;

    // behavioural reference state
    int m_st   = 0;
    int m_q[$];
    bit m_ovf  = 1'b0;
    int m_free = 0;

    task automatic chk(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(string req, bit cs, bit csq, bit rsq, bit v, int tag, bit full, int fr);
        bit push = 0, pop = 0, stall = 0, stp = 0, flush = 0;
        bit sq;
        int nxt;
        int rem;
        @(negedge clk);
        commit_stall_i  = cs;
        commit_squash_i = csq;
        rob_squash_i    = rsq;
        up_valid_i      = v;
        up_tag_i        = TW'(tag);
        queue_full_i    = full;
        queue_free_i    = FW'(fr);
        #5ns;
        sq  = csq || rsq;
        nxt = m_st;
        if (m_st == 0 || m_st == 1 || m_st == 3) begin
            if (cs) begin
                nxt = 2; push = v;
            end else if (sq) begin
                nxt = 4; flush = 1;
            end else if (full && v) begin
                nxt = 2; push = 1; stall = 1;
            end else if (m_st == 3) begin
                pop   = (m_q.size() > 0);
                push  = v;
                rem   = m_q.size() - int'(pop) + int'(push);
                stall = (rem != 0);
                nxt   = stall ? 3 : 1;
            end else if (v) begin
                nxt = 1;
            end
        end else if (m_st == 2) begin
            stall = 1;
            if (sq) begin
                nxt = 4; flush = 1;
            end else begin
                push = v;
                if (!cs && !full) nxt = 3;
            end
        end else if (m_st == 4) begin
            if (sq) stp = 1;
            else nxt = 1;
        end
        chk(req, "state", int'(state_o), m_st);
        chk(req, "stall", int'(up_stall_o), int'(stall));
        chk(req, "push", int'(skid_push_o), int'(push));
        chk(req, "pop", int'(skid_pop_o), int'(pop));
        chk(req, "empty", int'(skid_empty_o), int'(m_q.size() == 0));
        chk(req, "squash_step", int'(squash_step_o), int'(stp));
        chk(req, "overflow", int'(overflow_o), int'(m_ovf));
        chk(req, "free_cnt", int'(free_cnt_o), m_free);
        if (pop) chk(req, "head_tag", int'(skid_head_o), m_q[0]);
        @(posedge clk);
        if (flush) begin
            m_q.delete();
        end else begin
            if (pop) void'(m_q.pop_front());
            if (push) begin
                if (m_q.size() < DEPTH) m_q.push_back(tag);
                else m_ovf = 1'b1;
            end
        end
        m_st   = nxt;
        m_free = fr;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: reset values
        repeat (2) @(negedge clk);
        #5ns;
        chk("R1", "state", int'(state_o), 0);
        chk("R1", "stall", int'(up_stall_o), 0);
        chk("R1", "empty", int'(skid_empty_o), 1);
        chk("R1", "overflow", int'(overflow_o), 0);
        chk("R1", "free_cnt", int'(free_cnt_o), 0);
        chk("R1", "squash_step", int'(squash_step_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: idle holds, valid group starts running
        step("R9", 0, 0, 0, 0, 0, 0, 7);
        step("R9", 0, 0, 0, 0, 0, 0, 9);
        step("R9", 0, 0, 0, 1, 8'h05, 0, 3);
        step("R9", 0, 0, 0, 0, 0, 0, 3);

        // R2: stall wins over squash, group pushed on entry
        step("R2", 1, 1, 0, 1, 8'h11, 0, 12);
        // R3: blocked keeps stalling and collects groups
        step("R3", 1, 0, 0, 1, 8'h12, 0, 13);
        step("R3", 1, 0, 0, 1, 8'h13, 0, 14);
        // R4: full queue keeps blocked, then release to unblocking
        step("R4", 0, 0, 0, 0, 0, 1, 0);
        step("R4", 0, 0, 0, 0, 0, 0, 1);
        // R5, R12: drain in order
        step("R5", 0, 0, 0, 0, 0, 0, 2);
        step("R12", 0, 0, 0, 0, 0, 0, 2);
        step("R5", 0, 0, 0, 0, 0, 0, 2);
        step("R5", 0, 0, 0, 0, 0, 0, 2);

        // R8: full queue with valid group blocks and stalls at once
        step("R8", 0, 0, 0, 1, 8'h21, 1, 0);
        step("R8", 0, 0, 0, 0, 0, 0, 4);
        // R5: push during drain goes behind
        step("R5", 0, 0, 0, 1, 8'h22, 0, 4);
        step("R5", 0, 0, 0, 0, 0, 0, 4);
        step("R5", 0, 0, 0, 0, 0, 0, 4);

        // R4: squash from blocked flushes skid
        step("R4", 1, 0, 0, 1, 8'h31, 0, 5);
        step("R4", 1, 0, 0, 1, 8'h32, 0, 5);
        step("R4", 1, 0, 1, 1, 8'h33, 0, 5);
        // R6: squash held by either flag, then release
        step("R6", 0, 0, 1, 0, 0, 0, 6);
        step("R6", 0, 1, 0, 0, 0, 0, 6);
        step("R6", 0, 1, 1, 0, 0, 0, 6);
        step("R6", 0, 0, 0, 0, 0, 0, 6);
        // R7: squash from running
        step("R7", 0, 1, 0, 1, 8'h41, 0, 8);
        step("R7", 0, 0, 0, 0, 0, 0, 8);
        step("R11", 0, 0, 0, 0, 0, 0, 63);
        step("R11", 0, 0, 0, 0, 0, 0, 17);

        // R10: overflow of a four-entry skid buffer
        step("R10", 1, 0, 0, 1, 8'h51, 0, 1);
        for (int i = 0; i < 5; i++) step("R10", 1, 0, 0, 1, 8'h52 + i, 0, 1);
        step("R10", 0, 0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 5; i++) step("R12", 0, 0, 0, 0, 0, 0, 1);
        step("R10", 0, 0, 0, 0, 0, 0, 1);

        // R12: random mixture compared every cycle
        for (int i = 0; i < 600; i++) begin
            step("R12", ($urandom % 4) == 0, ($urandom % 9) == 0, ($urandom % 11) == 0,
                 ($urandom % 2) == 0, int'($urandom % 256), ($urandom % 5) == 0,
                 int'($urandom % 64));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule